// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns one active-low external interrupt pin into a maskable interrupt request for a processor core. The pin is first brought into the clock domain by a chain of synchronizer flops. A high-to-low change of the synchronized level then sets an interrupt latch. The latch stays set until the core signals that it has fetched the interrupt vector, software writes the acknowledge bit, or reset occurs.

A small control and status register, reached over a plain write/read port, holds three settings. A sensitivity bit chooses between falling edge only and falling edge plus low level. A mask bit blocks the request from reaching the core. A write-one acknowledge bit clears the latch. The register also shows whether an interrupt is pending. In the edge-plus-level setting the request does not drop until two things have both happened: the interrupt has been acknowledged, and the pin has gone high again.

Top module: `extint_ctrl`

## Requirements
- R1: A synchronized 1-to-0 change of `irq_n` sets the interrupt latch in either sensitivity setting. With the mask clear, `cpu_irq` goes high on the 4th rising clock edge after the pin falls, and not before.
- R2: A one-cycle pulse on `vec_ack` clears the latch. With the mask clear, `cpu_irq` is low after the 2nd edge following the pulse.
- R3: A register write with bit 2 of `reg_wdata` set clears the latch. A write with bit 2 clear does not touch the latch.
- R4: Synchronous reset clears the latch, the mode bit and the mask bit. After reset, `cpu_irq` is 0 and `reg_rdata` is all zeros.
- R5: `reg_rdata` shows the mode bit in bit 0, the mask bit in bit 1, the pending flag in bit 3, and a constant 0 in bit 2 and in every bit above 3. The write port sets mode from `reg_wdata[0]` and mask from `reg_wdata[1]`. The read value lags the register state by one clock.
- R6: With mode 0 (edge only), the request stays high after an edge whatever the pin does, until an acknowledge or reset clears it.
- R7: With mode 1 (edge plus level), the request stays high until an acknowledge has happened and the synchronized pin is high, in either order.
- R8: With the mask bit set, `cpu_irq` is held low, but the latch still sets and the pending flag reads 1. `cpu_irq` rises on the edge after the one that clears the mask.
- R9: When an edge and an acknowledge fall in the same cycle, the edge wins and the latch stays set.
- R10: With mode 0, a pin held low after an acknowledge raises no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Asynchronous active-low interrupt pin |
| vec_ack | input | 1 | One-cycle strobe from the core on interrupt vector fetch |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 3 | Write data: bit 0 mode, bit 1 mask, bit 2 acknowledge |
| reg_rdata | output | RD_W | Registered read value of the control/status register |
| cpu_irq | output | 1 | Registered interrupt request to the core |

## Verification
A pin fall reaches `cpu_irq` and the pending flag on the 4th rising edge: two synchronizer stages, the latch, then the output register. The bench samples one edge early to see the request still low, and again on the due edge. An acknowledge, whether a strobe or a register write, takes effect at the latch on the edge that captures it, so the output is checked one edge later. A mask change shows on `cpu_irq` one edge after it is written. In edge-plus-level mode, a pin that returns high drops the request on the 4th edge, and the bench checks the 3rd and the 4th. All inputs change just after a falling edge and all outputs are read at falling edges, so every check sits at a known edge count from its stimulus.

// File: rtl/extint_pkg.sv
package extint_pkg;
  // Register bit positions; software decodes these.
  localparam int MODE_BIT = 0;
  localparam int MASK_BIT = 1;
  localparam int ACK_BIT  = 2;
  localparam int PEND_BIT = 3;
  localparam int WR_W     = ACK_BIT + 1;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b1;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/extint_latch.sv
module extint_latch (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic mode,
  input  logic vec_ack,
  input  logic sw_ack,
  output logic pend
);
  logic prev_q, latch_q, hold_q, fall;

  always_comb fall = prev_q & ~lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (fall)                   latch_q <= 1'b1;
      else if (vec_ack || sw_ack) latch_q <= 1'b0;
      if (fall)     hold_q <= 1'b1;
      else if (lvl) hold_q <= 1'b0;
    end
  end

  assign pend = latch_q | (mode & hold_q);

  // R1: an edge always leaves the latch set
  assert_edge_sets_R1: assert property (@(posedge clk) disable iff (rst)
    fall |=> latch_q);
  // R2: a vector fetch with no edge clears the latch
  assert_vec_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && !fall) |=> !latch_q);
  // R3: a software acknowledge with no edge clears the latch
  assert_sw_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (sw_ack && !fall) |=> !latch_q);
  // R6: with no acknowledge the latch holds
  assert_latch_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (latch_q && !vec_ack && !sw_ack) |=> latch_q);
endmodule

// File: rtl/extint_csr.sv
module extint_csr
  import extint_pkg::*;
#(
  parameter int RD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [WR_W-1:0] wdata,
  input  logic            pend,
  output logic            mode,
  output logic            mask,
  output logic            sw_ack,
  output logic [RD_W-1:0] rdata
);
  logic [RD_W-1:0] rd_next;

  assign sw_ack = wr & wdata[ACK_BIT];

  always_comb begin
    rd_next           = '0;
    rd_next[MODE_BIT] = mode;
    rd_next[MASK_BIT] = mask;
    rd_next[PEND_BIT] = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= 1'b0;
      mask  <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr) begin
        mode <= wdata[MODE_BIT];
        mask <= wdata[MASK_BIT];
      end
      rdata <= rd_next;
    end
  end

  // R5: the acknowledge bit never reads back as one
  assert_ack_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !rdata[ACK_BIT]);
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int RD_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_n,
  input  logic            vec_ack,
  input  logic            reg_wr,
  input  logic [WR_W-1:0] reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  output logic            cpu_irq
);
  logic lvl, mode, mask, sw_ack, pend;

  extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(irq_n), .dout(lvl));

  extint_latch u_latch (
    .clk(clk), .rst(rst), .lvl(lvl), .mode(mode),
    .vec_ack(vec_ack), .sw_ack(sw_ack), .pend(pend));

  extint_csr #(.RD_W(RD_W)) u_csr (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata), .pend(pend),
    .mode(mode), .mask(mask), .sw_ack(sw_ack), .rdata(reg_rdata));

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= pend & ~mask;
  end

  // R8: a set mask keeps the request low on the next edge
  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    mask |=> !cpu_irq);
  // R7: in level mode a low pin keeps a pending request pending
  assert_level_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (mode && pend && !lvl && !reg_wr) |=> pend);
  // R4: the first cycle after reset shows no request and a clear register
  assert_reset_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_irq && reg_rdata == '0));
endmodule

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb_top;
  localparam int RD_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_n = 1'b1;
  logic vec_ack = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_wdata = '0;
  logic [RD_W-1:0] reg_rdata;
  logic cpu_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  extint_ctrl #(.RD_W(RD_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .irq_n(irq_n), .vec_ack(vec_ack),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_vec();
    vec_ack = 1'b1;
    tick(1);
    vec_ack = 1'b0;
  endtask

  // Bring pin high, clear the latch, set mode/mask, let things settle
  task automatic idle(input logic [1:0] mode_mask);
    irq_n = 1'b1;
    tick(4);
    wr_reg({1'b1, mode_mask});
    tick(2);
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(3); rst = 1'b0; tick(1);
    chk("R4 irq after reset", {7'b0, cpu_irq}, 8'h00);
    chk("R4 rdata after reset", reg_rdata, 8'h00);
  endtask

  task automatic t_edge_latency();
    idle(2'b00);
    irq_n = 1'b0;
    tick(3);
    chk("R1 irq not before 4th edge", {7'b0, cpu_irq}, 8'h00);
    tick(1);
    chk("R1 irq on 4th edge", {7'b0, cpu_irq}, 8'h01);
    chk("R5 pending flag bit3", reg_rdata, 8'h08);
    irq_n = 1'b1;
    tick(6);
    chk("R6 mode0 holds with pin high", {7'b0, cpu_irq}, 8'h01);
    pulse_vec();
    tick(1);
    chk("R2 vector fetch clears", {7'b0, cpu_irq}, 8'h00);
  endtask

  task automatic t_sw_ack();
    idle(2'b00);
    irq_n = 1'b0; tick(4);
    wr_reg(3'b000);
    tick(1);
    chk("R3 write zero ack ignored", {7'b0, cpu_irq}, 8'h01);
    chk("R3 pending after zero write", reg_rdata, 8'h08);
    wr_reg(3'b100);
    tick(1);
    chk("R3 write one ack clears", {7'b0, cpu_irq}, 8'h00);
    tick(5);
    chk("R10 low pin raises nothing", {7'b0, cpu_irq}, 8'h00);
    chk("R10 no pending", reg_rdata, 8'h00);
    irq_n = 1'b1;
  endtask

  task automatic t_layout();
    idle(2'b00);
    wr_reg(3'b111);
    tick(1);
    chk("R5 mode+mask readback", reg_rdata, 8'h03);
    wr_reg(3'b001);
    tick(1);
    chk("R5 mode only readback", reg_rdata, 8'h01);
    wr_reg(3'b100);
    tick(1);
    chk("R5 all clear readback", reg_rdata, 8'h00);
  endtask

  task automatic t_level_ack_first();
    idle(2'b01);
    irq_n = 1'b0; tick(4);
    chk("R1 mode1 edge sets", {7'b0, cpu_irq}, 8'h01);
    pulse_vec();
    tick(4);
    chk("R7 ack while low keeps irq", {7'b0, cpu_irq}, 8'h01);
    chk("R7 still pending", reg_rdata, 8'h09);
    irq_n = 1'b1;
    tick(3);
    chk("R7 irq until release seen", {7'b0, cpu_irq}, 8'h01);
    tick(1);
    chk("R7 drops after release", {7'b0, cpu_irq}, 8'h00);
  endtask

  task automatic t_level_release_first();
    idle(2'b01);
    irq_n = 1'b0; tick(4);
    irq_n = 1'b1; tick(6);
    chk("R7 release alone keeps irq", {7'b0, cpu_irq}, 8'h01);
    pulse_vec();
    tick(1);
    chk("R7 ack after release clears", {7'b0, cpu_irq}, 8'h00);
  endtask

  task automatic t_mask();
    idle(2'b10);
    irq_n = 1'b0; tick(4);
    chk("R8 masked irq low", {7'b0, cpu_irq}, 8'h00);
    chk("R8 pending visible", reg_rdata, 8'h0a);
    wr_reg(3'b000);
    chk("R8 not before next edge", {7'b0, cpu_irq}, 8'h00);
    tick(1);
    chk("R8 irq after unmask", {7'b0, cpu_irq}, 8'h01);
    irq_n = 1'b1;
    wr_reg(3'b100);
  endtask

  task automatic t_collision();
    idle(2'b00);
    irq_n = 1'b0;
    tick(2);
    vec_ack = 1'b1; tick(1); vec_ack = 1'b0;
    tick(1);
    chk("R9 edge beats vec ack", {7'b0, cpu_irq}, 8'h01);
    irq_n = 1'b1; tick(3);
    irq_n = 1'b0; tick(2);
    wr_reg(3'b100);
    tick(1);
    chk("R9 edge beats sw ack", {7'b0, cpu_irq}, 8'h01);
    irq_n = 1'b1;
  endtask

  task automatic t_mid_reset();
    idle(2'b11);
    irq_n = 1'b0; tick(4);
    irq_n = 1'b1; tick(3);
    t_reset();
    tick(4);
    chk("R4 latch stays clear", reg_rdata, 8'h00);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_edge_latency();
    t_sw_ack();
    t_layout();
    t_level_ack_first();
    t_level_release_first();
    t_mask();
    t_collision();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule